// File: doc/BRIEF.md
# Presence-Vector Snoop Filter

This block sits between a group of caching nodes and the shared coherence interconnect. It keeps a small 4-way set-associative directory of line addresses. Every line that any node may hold has an entry, and each entry has one presence bit per node. For each coherence request, a single-cycle lookup returns a registered mask of the nodes that must be snooped. That mask covers only the other nodes whose bit is set, so requests are no longer broadcast to every node. A request that misses in the directory snoops no node and is sent straight to memory.

Reads add the requester to the line's owners. A write leaves the writer as the only owner, and the other owners are named in the snoop mask so they can be invalidated. A node that drops a line sends an eviction notice, which clears that node's bit. An entry whose vector becomes empty is released. A miss into a set with no free way picks a victim: the way with the fewest owners, with ties going to the lowest way. The block then holds a back-invalidate toward all of the victim's owners and stalls new requests. The new line is installed once every owner has acknowledged.

Top module: `snoop_filter`

## Requirements
- R1: A read that hits returns hit=1, to_mem=0 and a snoop mask equal to the line's presence vector with the requester's own bit removed. The requester's bit is set afterwards.
- R2: A read or write that misses returns hit=0, an all-zero snoop mask and to_mem=1.
- R3: A write that hits returns a snoop mask of all other present nodes. Afterwards only the writer's bit remains set in that line's vector.
- R4: An eviction notice (op code 2) clears the sender's presence bit and produces no response. When the vector becomes zero the entry is freed, so a later request to that line misses.
- R5: A miss into a set with a free way installs the line with only the requester present. This raises no back-invalidate.
- R6: A miss into a full set picks as victim the way whose vector has the fewest set bits, with the lowest way index winning ties. It raises binv_valid with binv_mask equal to the victim's vector and binv_addr equal to the victim's line address ({tag, set}).
- R7: While a back-invalidate is pending, req_ready is low and binv_valid stays high. Acknowledgements from nodes outside binv_mask are ignored. Once every node in binv_mask has acknowledged, the new line replaces the victim, which then misses.
- R8: A read (op code 0) or write (op code 1) accepted on a clock edge produces exactly one response, visible from that same edge until the next.
- R9: After reset no response or back-invalidate is pending, req_ready is high and every address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Filter can accept a request |
| req_op | input | 2 | 0 read, 1 write, 2 eviction notice |
| req_node | input | NODE_W | Requesting node index |
| req_addr | input | ADDR_W | Line address; low SET_W bits pick the set |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Line was tracked |
| rsp_snoop_mask | output | NODES | Nodes to snoop |
| rsp_to_mem | output | 1 | Forward request to memory |
| binv_valid | output | 1 | Back-invalidate pending |
| binv_mask | output | NODES | Nodes that must drop the victim line |
| binv_addr | output | ADDR_W | Victim line address |
| binv_ack_valid | input | 1 | A node acknowledges the back-invalidate |
| binv_ack_node | input | NODE_W | Acknowledging node index |

## Verification
The bench builds the filter with 4 nodes, 4 sets and 6-bit line addresses. With these values a single set fills after four distinct lines, so victim selection is easy to reach. The test covers a tie on the smallest owner count, a victim with two owners that needs two acknowledgements, and a stray acknowledgement that must be ignored. Four nodes also make every mask value readable by hand, including the write case where only the writer stays present.

// File: rtl/snoop_filter_pkg.sv
package snoop_filter_pkg;

    localparam int WAYS  = 4;
    localparam int WAY_W = 2;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2
    } sf_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } sf_state_e;

    // population count of a presence vector (up to 32 nodes)
    function automatic logic [5:0] owner_count(input logic [31:0] v);
        logic [5:0] c;
        c = '0;
        for (int i = 0; i < 32; i++) begin
            c = c + 6'(v[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/snoop_filter_match.sv
module snoop_filter_match
    import snoop_filter_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic [WAYS-1:0]            row_vld,
    input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
    input  logic [TAG_W-1:0]           tag_in,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic                       free_any,
    output logic [WAY_W-1:0]           free_way
);

    logic [WAYS-1:0] match;
    logic [WAYS-1:0] empty;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = row_vld[w] && (row_tag[w] == tag_in);
        assign empty[w] = !row_vld[w];
    end

    assign hit      = |match;
    assign free_any = |empty;

    // lowest index wins for both encoders
    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way  = WAY_W'(w);
            if (empty[w]) free_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/snoop_filter_victim.sv
module snoop_filter_victim
    import snoop_filter_pkg::*;
#(
    parameter int NODES = 4
) (
    input  logic [WAYS-1:0][NODES-1:0] row_pv,
    output logic [WAY_W-1:0]           victim_way
);

    logic [5:0] best_cnt;
    logic [5:0] cnt;

    // strict less-than keeps the lowest way on equal counts
    always_comb begin
        victim_way = '0;
        best_cnt   = owner_count(32'(row_pv[0]));
        for (int w = 1; w < WAYS; w++) begin
            cnt = owner_count(32'(row_pv[w]));
            if (cnt < best_cnt) begin
                best_cnt   = cnt;
                victim_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/snoop_filter.sv
module snoop_filter
    import snoop_filter_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int SETS   = 16,
    parameter int ADDR_W = 16,
    localparam int NODE_W = $clog2(NODES),
    localparam int SET_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - SET_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [NODE_W-1:0] req_node,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [NODES-1:0]  rsp_snoop_mask,
    output logic              rsp_to_mem,
    output logic              binv_valid,
    output logic [NODES-1:0]  binv_mask,
    output logic [ADDR_W-1:0] binv_addr,
    input  logic              binv_ack_valid,
    input  logic [NODE_W-1:0] binv_ack_node
);

    // directory storage
    logic             ent_vld [SETS][WAYS];
    logic [TAG_W-1:0] ent_tag [SETS][WAYS];
    logic [NODES-1:0] ent_pv  [SETS][WAYS];

    sf_state_e         state;
    logic [WAY_W-1:0]  vic_way;
    logic [SET_W-1:0]  pend_set;
    logic [TAG_W-1:0]  pend_tag;
    logic [NODES-1:0]  pend_self;
    logic [NODES-1:0]  ack_seen;

    sf_op_e            op;
    logic [SET_W-1:0]  set_idx;
    logic [TAG_W-1:0]  tag_in;
    logic [NODES-1:0]  self_bit;
    logic              accept;

    logic [WAYS-1:0]             row_vld;
    logic [WAYS-1:0][TAG_W-1:0]  row_tag;
    logic [WAYS-1:0][NODES-1:0]  row_pv;

    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic              free_any;
    logic [WAY_W-1:0]  free_way;
    logic [WAY_W-1:0]  victim_way;
    logic [NODES-1:0]  hit_pv;
    logic [NODES-1:0]  evict_pv;
    logic [NODES-1:0]  ack_bit;
    logic [NODES-1:0]  seen_next;

    assign op        = sf_op_e'(req_op);
    assign set_idx   = req_addr[SET_W-1:0];
    assign tag_in    = req_addr[ADDR_W-1:SET_W];
    assign self_bit  = NODES'(1) << req_node;
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign binv_valid = (state == ST_DRAIN);

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            row_vld[w] = ent_vld[set_idx][w];
            row_tag[w] = ent_tag[set_idx][w];
            row_pv[w]  = ent_pv[set_idx][w];
        end
    end

    snoop_filter_match #(.TAG_W(TAG_W)) u_match (
        .row_vld  (row_vld),
        .row_tag  (row_tag),
        .tag_in   (tag_in),
        .hit      (hit),
        .hit_way  (hit_way),
        .free_any (free_any),
        .free_way (free_way)
    );

    snoop_filter_victim #(.NODES(NODES)) u_victim (
        .row_pv     (row_pv),
        .victim_way (victim_way)
    );

    assign hit_pv    = row_pv[hit_way];
    assign evict_pv  = hit_pv & ~self_bit;
    assign ack_bit   = NODES'(1) << binv_ack_node;
    assign seen_next = ack_seen | (ack_bit & binv_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= ST_IDLE;
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_snoop_mask <= '0;
            rsp_to_mem     <= 1'b0;
            binv_mask      <= '0;
            binv_addr      <= '0;
            vic_way        <= '0;
            pend_set       <= '0;
            pend_tag       <= '0;
            pend_self      <= '0;
            ack_seen       <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    ent_vld[s][w] <= 1'b0;
                    ent_tag[s][w] <= '0;
                    ent_pv[s][w]  <= '0;
                end
            end
        end else begin
            rsp_valid <= accept && (op != OP_EVICT);
            if (accept) begin
                if (op == OP_EVICT) begin
                    if (hit) begin
                        ent_pv[set_idx][hit_way] <= evict_pv;
                        if (evict_pv == '0) ent_vld[set_idx][hit_way] <= 1'b0;
                    end
                end else begin
                    rsp_hit        <= hit;
                    rsp_snoop_mask <= hit ? (hit_pv & ~self_bit) : '0;
                    rsp_to_mem     <= !hit;
                    if (hit) begin
                        ent_pv[set_idx][hit_way] <=
                            (op == OP_WRITE) ? self_bit : (hit_pv | self_bit);
                    end else if (free_any) begin
                        ent_vld[set_idx][free_way] <= 1'b1;
                        ent_tag[set_idx][free_way] <= tag_in;
                        ent_pv[set_idx][free_way]  <= self_bit;
                    end else begin
                        state     <= ST_DRAIN;
                        vic_way   <= victim_way;
                        pend_set  <= set_idx;
                        pend_tag  <= tag_in;
                        pend_self <= self_bit;
                        ack_seen  <= '0;
                        binv_mask <= row_pv[victim_way];
                        binv_addr <= {row_tag[victim_way], set_idx};
                    end
                end
            end
            if (state == ST_DRAIN && binv_ack_valid) begin
                ack_seen <= seen_next;
                if (seen_next == binv_mask) begin
                    state <= ST_IDLE;
                    ent_vld[pend_set][vic_way] <= 1'b1;
                    ent_tag[pend_set][vic_way] <= pend_tag;
                    ent_pv[pend_set][vic_way]  <= pend_self;
                end
            end
        end
    end

    // ---------------- assertions ----------------
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready && req_op != 2'd2)); // R8

    AST_MISS_TO_MEM: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_snoop_mask == '0 && rsp_to_mem)); // R2

    AST_NO_SELF_SNOOP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ((rsp_snoop_mask & (NODES'(1) << $past(req_node))) == '0)); // R1

    AST_BINV_HAS_OWNER: assert property (@(posedge clk) disable iff (rst)
        binv_valid |-> (binv_mask != '0)); // R6

    AST_DRAIN_ON_FULL_MISS: assert property (@(posedge clk) disable iff (rst)
        $rose(binv_valid) |-> $past(accept && !hit && !free_any)); // R5

    AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (binv_valid && !binv_ack_valid) |=> binv_valid); // R7

endmodule

// File: tb/snoop_filter_tb.sv
module snoop_filter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NODES  = 4;
    localparam int SETS   = 4;
    localparam int ADDR_W = 6;
    localparam int NODE_W = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = '0;
    logic [NODE_W-1:0] req_node = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [NODES-1:0]  rsp_snoop_mask;
    logic              rsp_to_mem;
    logic              binv_valid;
    logic [NODES-1:0]  binv_mask;
    logic [ADDR_W-1:0] binv_addr;
    logic              binv_ack_valid = 1'b0;
    logic [NODE_W-1:0] binv_ack_node = '0;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    typedef struct {
        logic       hit;
        logic [3:0] mask;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_filter #(.NODES(NODES), .SETS(SETS), .ADDR_W(ADDR_W)) u_dut (
        .clk, .rst, .req_valid, .req_ready, .req_op, .req_node, .req_addr,
        .rsp_valid, .rsp_hit, .rsp_snoop_mask, .rsp_to_mem,
        .binv_valid, .binv_mask, .binv_addr, .binv_ack_valid, .binv_ack_node
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: one request, expected response queued for the monitor
    task automatic send(input logic [1:0] op, input int node, input logic [5:0] addr,
                        input logic ehit, input logic [3:0] emask, input string req);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_node  = NODE_W'(node);
        req_addr  = addr;
        if (op != 2'd2) begin
            e.hit = ehit; e.mask = emask; e.req = req;
            exp_q.push_back(e);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ack(input int node);
        @(negedge clk);
        binv_ack_valid = 1'b1;
        binv_ack_node  = NODE_W'(node);
        @(negedge clk);
        binv_ack_valid = 1'b0;
    endtask

    // monitor: compares each response against the scoreboard
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R8", "unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.req, "hit", 32'(rsp_hit), 32'(e.hit));
                chk(e.req, "snoop_mask", 32'(rsp_snoop_mask), 32'(e.mask));
                chk(e.req, "to_mem", 32'(rsp_to_mem), 32'(!e.hit));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9", "req_ready", 32'(req_ready), 32'd1);
        chk("R9", "rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R9", "binv_valid", 32'(binv_valid), 32'd0);

        // set 0 : line 0x00
        send(2'd0, 0, 6'h00, 1'b0, 4'b0000, "R2_R9");   // first access misses
        send(2'd0, 1, 6'h00, 1'b1, 4'b0001, "R1");
        send(2'd0, 2, 6'h00, 1'b1, 4'b0011, "R1");
        send(2'd1, 1, 6'h00, 1'b1, 4'b0101, "R3");      // write snoops others
        send(2'd0, 3, 6'h00, 1'b1, 4'b0010, "R3");      // only writer left
        send(2'd1, 2, 6'h05, 1'b0, 4'b0000, "R2");      // write miss, set 1

        // fill remaining ways of set 0
        send(2'd0, 0, 6'h04, 1'b0, 4'b0000, "R5");
        send(2'd0, 1, 6'h04, 1'b1, 4'b0001, "R1");
        send(2'd0, 2, 6'h08, 1'b0, 4'b0000, "R5");
        send(2'd0, 3, 6'h0C, 1'b0, 4'b0000, "R5");
        chk("R5", "no binv with free way", 32'(binv_valid), 32'd0);

        // full set: counts 2,2,1,1 -> way holding 0x08 (tie, lowest)
        send(2'd0, 0, 6'h10, 1'b0, 4'b0000, "R6");
        chk("R6", "binv_valid", 32'(binv_valid), 32'd1);
        chk("R6", "binv_mask", 32'(binv_mask), 32'b0100);
        chk("R6", "binv_addr", 32'(binv_addr), 32'h08);
        chk("R7", "ready low", 32'(req_ready), 32'd0);
        repeat (3) @(negedge clk);
        chk("R7", "binv held", 32'(binv_valid), 32'd1);
        chk("R7", "ready still low", 32'(req_ready), 32'd0);
        ack(2);
        chk("R7", "binv done", 32'(binv_valid), 32'd0);
        chk("R7", "ready back", 32'(req_ready), 32'd1);

        // 0x08 was replaced: misses; new victim 0x10 (1 owner, lowest tie)
        send(2'd0, 1, 6'h08, 1'b0, 4'b0000, "R7");
        chk("R6", "binv_mask second", 32'(binv_mask), 32'b0001);
        chk("R6", "binv_addr second", 32'(binv_addr), 32'h10);
        ack(0);
        send(2'd0, 2, 6'h08, 1'b1, 4'b0010, "R7");       // installed with n1

        // eviction notices
        send(2'd2, 3, 6'h0C, 1'b0, 4'b0000, "R4");
        chk("R4", "evict no response", 32'(rsp_valid), 32'd0);
        send(2'd0, 0, 6'h0C, 1'b0, 4'b0000, "R4");       // freed -> miss
        chk("R4", "freed way reused", 32'(binv_valid), 32'd0);
        send(2'd2, 1, 6'h00, 1'b0, 4'b0000, "R4");       // pv 1010 -> 1000
        send(2'd1, 0, 6'h00, 1'b1, 4'b1000, "R4");

        // set 1: 0x05 held by n2 (1); fill to full
        send(2'd0, 0, 6'h01, 1'b0, 4'b0000, "R2");
        send(2'd0, 1, 6'h01, 1'b1, 4'b0001, "R1");
        send(2'd0, 0, 6'h05, 1'b1, 4'b0100, "R1");       // 0x05 -> 0101
        send(2'd0, 0, 6'h09, 1'b0, 4'b0000, "R5");
        send(2'd0, 1, 6'h09, 1'b1, 4'b0001, "R1");
        send(2'd0, 2, 6'h09, 1'b1, 4'b0011, "R1");
        send(2'd0, 3, 6'h0D, 1'b0, 4'b0000, "R5");
        send(2'd0, 2, 6'h0D, 1'b1, 4'b1000, "R1");
        // counts: 0x05=2 (way0), 0x01=2, 0x09=3, 0x0D=2 -> way0 (0x05)
        send(2'd0, 3, 6'h11, 1'b0, 4'b0000, "R6");
        chk("R6", "binv_mask multi", 32'(binv_mask), 32'b0101);
        chk("R6", "binv_addr multi", 32'(binv_addr), 32'h05);
        ack(1);                                          // not an owner
        chk("R7", "stray ack ignored", 32'(binv_valid), 32'd1);
        ack(0);
        chk("R7", "partial ack waits", 32'(req_ready), 32'd0);
        ack(2);
        chk("R7", "all acks release", 32'(req_ready), 32'd1);
        send(2'd0, 1, 6'h11, 1'b1, 4'b1000, "R7");
        send(2'd1, 2, 6'h01, 1'b1, 4'b0011, "R3");

        repeat (2) @(negedge clk);
        chk("R8", "scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule